// File: doc/BRIEF.md
# Framed Synchronous Serial Port

This block moves data words over a three-wire synchronous serial link. It drives a serial clock, a frame sync and a data output, and samples a data input. The link carries frames. Each frame holds a programmable number of back-to-back words, and each word has a programmable length of 1 to 16 bits. The frame length is set in serial clock periods. The first period of every frame is reserved as the sync slot, so data begins in the second period. Any periods left after the last word are idle.

One mode input chooses where the frame sync appears. In pulse mode the sync is a single serial clock period long and sits in the slot just before the first data bit. In wide mode the sync rises with the first data bit and stays high for the whole of the first word. Words to send are written into a small transmit FIFO. Received words collect in a small receive FIFO, which software reads in the order the words arrived. An interrupt reports that the transmit FIFO is running low. Two sticky flags record an empty transmit FIFO at the start of a word and a full receive FIFO at the end of a word.

The serial clock runs at half the rate of the system clock and toggles continuously once reset has been released. All configuration inputs are meant to change only while the port is stopped.

Top module: `ssp_port`

## Requirements
- R1: While reset is asserted, and right after it, `sclk_o`, `sync_o`, `sdo_o`, `tx_irq`, `underrun`, `overrun` and `rx_valid` are all 0, and both FIFOs are empty.
- R2: `sclk_o` toggles on every system clock. `sdo_o` and `sync_o` change only where `sclk_o` goes from 0 to 1. `sdi_i` is sampled where `sclk_o` goes from 1 to 0.
- R3: A frame lasts `frame_len` serial clock periods, numbered from slot 0, and `frame_len` must be at least 2. Word length is `word_len_m1`+1 and the number of words is `words_m1`+1. Data fills slots 1 to words×length with no gaps, each word sent MSB first, using bits length-1 down to 0 of the written value. Any slot after that, including slots cut off by a short frame, drives `sdo_o` = 0.
- R4: When `sync_mode` = 1 (pulse), `sync_o` is 1 in slot 0 of each frame and 0 in every other slot.
- R5: When `sync_mode` = 0 (wide), `sync_o` is 1 exactly during the slots of the first word and 0 otherwise.
- R6: The bits sampled during each completed word are assembled MSB first into the low bits of a word, with the upper bits zero, and pushed into the receive FIFO. `rx_valid` = 1 shows that `rx_data` holds the oldest word, and `rx_rd` removes it.
- R7: If the transmit FIFO is empty when a word begins, that word is sent as all zeros and `underrun` becomes 1 and stays 1 until reset.
- R8: If the receive FIFO is full when a word completes, the word is dropped, the stored words are kept, and `overrun` becomes 1 and stays 1 until reset.
- R9: `tx_irq` = 1 exactly when `tx_irq_en` = 1 and the transmit FIFO holds fewer words than `tx_thresh`.
- R10: Setting `enable` to 1 starts a frame at the next serial clock rise. Clearing it lets the current frame finish, after which `sync_o` and `sdo_o` stay 0 and no words are received.
- R11: A `tx_wr` while the transmit FIFO is full is ignored, and the FIFO holds at most `TX_DEPTH` words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run frames while 1 |
| sync_mode | input | 1 | 1 = one-slot pulse before data, 0 = sync across first word |
| word_len_m1 | input | LEN_W | Word length minus one |
| words_m1 | input | CNT_W | Words per frame minus one |
| frame_len | input | FRM_W | Frame length in serial clock periods |
| tx_irq_en | input | 1 | Transmit level interrupt enable |
| tx_thresh | input | TXC_W | Transmit FIFO level threshold |
| tx_wr | input | 1 | Write `tx_data` into the transmit FIFO |
| tx_data | input | 2**LEN_W | Word to transmit |
| rx_rd | input | 1 | Remove the oldest received word |
| rx_data | output | 2**LEN_W | Oldest received word |
| rx_valid | output | 1 | Receive FIFO not empty |
| sclk_o | output | 1 | Serial clock |
| sync_o | output | 1 | Frame sync |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| tx_irq | output | 1 | Transmit FIFO low interrupt |
| underrun | output | 1 | Sticky transmit underrun flag |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
Several rules are checked on every cycle: the serial outputs change only on a rising serial clock, the pulse-mode sync lasts exactly one serial clock period, both error flags stay set once raised, and neither FIFO ever holds more than its depth. Other behaviour can only be shown by the bench's scenarios. This covers the slot-by-slot bit order and sync placement in both modes, frames that cut off a word, words assembled on the receive side, dropped writes and dropped words, the interrupt level against the threshold, and the way the port winds down after a frame once `enable` is cleared.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    SYNC_WIDE  = 1'b0,
    SYNC_PULSE = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign dout    = mem_q[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    if (do_push && !do_pop)      cnt_n = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem_q[gi] <= '0;
      else if (do_push && wr_q == AW'(gi))       mem_q[gi] <= din;
    end
  end
endmodule

// File: rtl/ssp_framer.sv
module ssp_framer
  import ssp_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int CNT_W = 4,
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  sync_mode_e       mode,
  input  logic [LEN_W-1:0] wlen_m1,
  input  logic [CNT_W-1:0] wpf_m1,
  input  logic [FRM_W-1:0] frame_len,
  output logic             sclk,
  output logic             rise_en,
  output logic             fall_en,
  output logic             sync,
  output logic             act_nxt,
  output logic [LEN_W-1:0] bit_nxt,
  output logic             act_cur,
  output logic [LEN_W-1:0] bit_cur
);
  logic             sclk_q, sclk_n;
  logic             run_q, run_n;
  logic [FRM_W-1:0] slot_q, slot_n;
  logic             act_q, act_n;
  logic [LEN_W-1:0] bit_q, bit_n;
  logic [CNT_W-1:0] word_q, word_n;
  logic             sync_q, sync_n;

  assign rise_en = ~sclk_q;
  assign fall_en = sclk_q;

  always_comb begin
    sclk_n = ~sclk_q;
    run_n  = run_q;
    slot_n = slot_q;
    act_n  = act_q;
    bit_n  = bit_q;
    word_n = word_q;
    sync_n = sync_q;
    if (rise_en) begin
      if (run_q) begin
        if (slot_q == frame_len - FRM_W'(1)) begin
          slot_n = '0;
          run_n  = enable;
        end else begin
          slot_n = slot_q + FRM_W'(1);
        end
      end else if (enable) begin
        run_n  = 1'b1;
        slot_n = '0;
      end

      if (!run_n || slot_n == '0) begin
        act_n = 1'b0;
      end else if (slot_n == FRM_W'(1)) begin
        act_n  = 1'b1;
        bit_n  = '0;
        word_n = '0;
      end else if (act_q) begin
        if (bit_q == wlen_m1) begin
          bit_n = '0;
          if (word_q == wpf_m1) act_n = 1'b0;
          else                  word_n = word_q + CNT_W'(1);
        end else begin
          bit_n = bit_q + LEN_W'(1);
        end
      end

      if (mode == SYNC_PULSE) sync_n = run_n && (slot_n == '0);
      else                    sync_n = act_n && (word_n == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      run_q  <= 1'b0;
      slot_q <= '0;
      act_q  <= 1'b0;
      bit_q  <= '0;
      word_q <= '0;
      sync_q <= 1'b0;
    end else begin
      sclk_q <= sclk_n;
      run_q  <= run_n;
      slot_q <= slot_n;
      act_q  <= act_n;
      bit_q  <= bit_n;
      word_q <= word_n;
      sync_q <= sync_n;
    end
  end

  assign sclk    = sclk_q;
  assign sync    = sync_q;
  assign act_nxt = act_n;
  assign bit_nxt = bit_n;
  assign act_cur = act_q;
  assign bit_cur = bit_q;
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int LEN_W    = 4,
  parameter int CNT_W    = 4,
  parameter int FRM_W    = 8,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int TXC_W    = $clog2(TX_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  sync_mode,
  input  logic [LEN_W-1:0]      word_len_m1,
  input  logic [CNT_W-1:0]      words_m1,
  input  logic [FRM_W-1:0]      frame_len,
  input  logic                  tx_irq_en,
  input  logic [TXC_W-1:0]      tx_thresh,
  input  logic                  tx_wr,
  input  logic [2**LEN_W-1:0]   tx_data,
  input  logic                  rx_rd,
  output logic [2**LEN_W-1:0]   rx_data,
  output logic                  rx_valid,
  output logic                  sclk_o,
  output logic                  sync_o,
  output logic                  sdo_o,
  input  logic                  sdi_i,
  output logic                  tx_irq,
  output logic                  underrun,
  output logic                  overrun
);
  localparam int DW    = 2 ** LEN_W;
  localparam int RXC_W = $clog2(RX_DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  // frame timing
  logic             rise_en, fall_en, act_nxt, act_cur;
  logic [LEN_W-1:0] bit_nxt, bit_cur;

  ssp_framer #(.LEN_W(LEN_W), .CNT_W(CNT_W), .FRM_W(FRM_W)) i_framer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (enable),
    .mode      (sync_mode_e'(sync_mode)),
    .wlen_m1   (word_len_m1),
    .wpf_m1    (words_m1),
    .frame_len (frame_len),
    .sclk      (sclk_o),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .sync      (sync_o),
    .act_nxt   (act_nxt),
    .bit_nxt   (bit_nxt),
    .act_cur   (act_cur),
    .bit_cur   (bit_cur)
  );

  // FIFOs
  logic [DW-1:0]    tx_head, rx_word;
  logic             tx_full, tx_empty, tx_pop;
  logic             rx_full, rx_empty, rx_push;
  logic [TXC_W-1:0] tx_count;
  logic [RXC_W-1:0] rx_count;

  ssp_fifo #(.WIDTH(DW), .DEPTH(TX_DEPTH), .CW(TXC_W)) i_tx_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (tx_wr && !tx_full),
    .din   (tx_data),
    .pop   (tx_pop),
    .dout  (tx_head),
    .full  (tx_full),
    .empty (tx_empty),
    .count (tx_count)
  );

  ssp_fifo #(.WIDTH(DW), .DEPTH(RX_DEPTH), .CW(RXC_W)) i_rx_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (rx_push),
    .din   (rx_word),
    .pop   (rx_rd),
    .dout  (rx_data),
    .full  (rx_full),
    .empty (rx_empty),
    .count (rx_count)
  );

  assign rx_valid = !rx_empty;
  assign tx_irq   = tx_irq_en && (tx_count < tx_thresh);

  // transmit and receive datapath
  logic [DW-1:0] tx_word_q, tx_word_n, rx_sh_q, rx_sh_n, len_mask;
  logic          sdo_q, sdo_n, und_q, und_n, ovr_q, ovr_n, word_start;

  assign word_start = rise_en && act_nxt && (bit_nxt == '0);
  assign tx_pop     = word_start && !tx_empty;
  assign len_mask   = {DW{1'b1}} >> (~word_len_m1);

  always_comb begin
    tx_word_n = tx_word_q;
    sdo_n     = sdo_q;
    und_n     = und_q | (word_start && tx_empty);
    if (rise_en) begin
      if (!act_nxt) begin
        sdo_n = 1'b0;
      end else if (bit_nxt == '0) begin
        tx_word_n = tx_empty ? '0 : tx_head;
        sdo_n     = tx_empty ? 1'b0 : tx_head[word_len_m1];
      end else begin
        sdo_n = tx_word_q[word_len_m1 - bit_nxt];
      end
    end
  end

  always_comb begin
    rx_sh_n = rx_sh_q;
    rx_push = 1'b0;
    if (fall_en && act_cur) begin
      rx_sh_n = {rx_sh_q[DW-2:0], sdi_i};
      rx_push = (bit_cur == word_len_m1);
    end
    rx_word = rx_sh_n & len_mask;
    ovr_n   = ovr_q | (rx_push && rx_full);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tx_word_q <= '0;
      rx_sh_q   <= '0;
      sdo_q     <= 1'b0;
      und_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      tx_word_q <= tx_word_n;
      rx_sh_q   <= rx_sh_n;
      sdo_q     <= sdo_n;
      und_q     <= und_n;
      ovr_q     <= ovr_n;
    end
  end

  assign sdo_o    = sdo_q;
  assign underrun = und_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int TXC_W    = 4,
  parameter int RXC_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_o,
  input logic             sync_o,
  input logic             sdo_o,
  input logic             sync_mode,
  input logic             underrun,
  input logic             overrun,
  input logic [TXC_W-1:0] tx_count,
  input logic [RXC_W-1:0] rx_count
);
  // R2: serial data only moves as the serial clock rises
  a_r2_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> (sclk_o && !$past(sclk_o)));

  // R2: frame sync only moves as the serial clock rises
  a_r2_sync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_o) |-> (sclk_o && !$past(sclk_o)));

  // R4: pulse-mode sync lasts one serial clock period (two system clocks)
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && $rose(sync_o)) |=> sync_o ##1 !sync_o);

  // R7: underrun is sticky
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(underrun) |-> underrun);

  // R8: overrun is sticky
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) |-> overrun);

  // R11: transmit FIFO never above its depth
  a_r11_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= TXC_W'(TX_DEPTH));

  // R8: receive FIFO never above its depth
  a_r8_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RXC_W'(RX_DEPTH));
endmodule

bind ssp_port ssp_port_chk #(
  .TX_DEPTH (TX_DEPTH),
  .RX_DEPTH (RX_DEPTH),
  .TXC_W    (TXC_W),
  .RXC_W    (RXC_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk_o    (sclk_o),
  .sync_o    (sync_o),
  .sdo_o     (sdo_o),
  .sync_mode (sync_mode),
  .underrun  (underrun),
  .overrun   (overrun),
  .tx_count  (tx_count),
  .rx_count  (rx_count)
);

// File: tb/test_ssp_port.sv
module test_ssp_port;
  localparam int DW  = 16;
  localparam int TXD = 8;
  localparam int RXD = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, enable, sync_mode, tx_irq_en, tx_wr, rx_rd, sdi_i;
  logic [3:0]    word_len_m1, words_m1, tx_thresh;
  logic [7:0]    frame_len;
  logic [DW-1:0] tx_data, rx_data;
  logic          rx_valid, sclk_o, sync_o, sdo_o, tx_irq, underrun, overrun;

  ssp_port i_ssp_port (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
    .word_len_m1(word_len_m1), .words_m1(words_m1), .frame_len(frame_len),
    .tx_irq_en(tx_irq_en), .tx_thresh(tx_thresh), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid), .sclk_o(sclk_o),
    .sync_o(sync_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .tx_irq(tx_irq),
    .underrun(underrun), .overrun(overrun)
  );

  int n_run = 0, n_fail = 0;

  // bench-side model state
  int L = 1, W = 1, F = 2;
  bit m_prev = 0, m_run = 0, m_und = 0, m_ovr = 0;
  int m_slot = 0, m_frames = 0, m_cur = 0, rx_acc = 0;
  int tq[64]; int tq_h = 0, tq_t = 0, tq_n = 0;
  int rq[64]; int rq_h = 0, rq_t = 0, rq_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected behaviour at each serial clock rise (R2..R8, R10)
  task automatic rise_model();
    bit data, e_sdo, e_sync, sb;
    int j, b;
    if (m_run) begin
      if (m_slot == F - 1) begin
        if (enable) m_slot = 0; else m_run = 0;
      end else m_slot++;
    end else if (enable) begin
      m_run = 1; m_slot = 0;
    end
    if (m_run && m_slot == 0) m_frames++;
    data = m_run && m_slot >= 1 && m_slot <= W * L;
    j = data ? (m_slot - 1) / L : 0;
    b = data ? (m_slot - 1) % L : 0;
    if (data && b == 0) begin
      if (tq_n > 0) begin m_cur = tq[tq_h]; tq_h = (tq_h + 1) % 64; tq_n--; end
      else begin m_cur = 0; m_und = 1; end
    end
    e_sdo  = data ? 1'((m_cur >> (L - 1 - b)) & 1) : 1'b0;
    e_sync = sync_mode ? (m_run && m_slot == 0) : (data && j == 0);
    chk(sdo_o == e_sdo, "R3", "sdo in slot", int'(sdo_o), int'(e_sdo));
    if (sync_mode) chk(sync_o == e_sync, "R4", "pulse sync", int'(sync_o), int'(e_sync));
    else           chk(sync_o == e_sync, "R5", "wide sync", int'(sync_o), int'(e_sync));
    sb = 1'($urandom % 2);
    sdi_i = sb;
    if (data) begin
      rx_acc = ((rx_acc << 1) | int'(sb)) & ((1 << L) - 1);
      if (b == L - 1) begin
        if (rq_n < RXD) begin rq[rq_t] = rx_acc; rq_t = (rq_t + 1) % 64; rq_n++; end
        else m_ovr = 1;
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(sclk_o != m_prev, "R2", "sclk toggles", int'(sclk_o), int'(!m_prev));
    if (sclk_o && !m_prev) rise_model();
    m_prev = sclk_o;
  endtask

  task automatic push_tx(input int v);
    tx_data = DW'(v);
    tx_wr   = 1'b1;
    tick();
    tx_wr   = 1'b0;
    if (tq_n < TXD) begin tq[tq_t] = v & 16'hFFFF; tq_t = (tq_t + 1) % 64; tq_n++; end
  endtask

  task automatic fill_to(input int n);
    while (tq_n < n && tq_n < TXD) push_tx(int'($urandom));
  endtask

  task automatic set_cfg(input bit md, input int wl, input int wp, input int fl);
    sync_mode   = md;
    word_len_m1 = 4'(wl);
    words_m1    = 4'(wp);
    frame_len   = 8'(fl);
    L = wl + 1; W = wp + 1; F = fl;
    tick();
  endtask

  task automatic run_frames(input int n);
    int start;
    start  = m_frames;
    enable = 1'b1;
    while (m_frames < start + n) tick();
    enable = 1'b0;
    while (m_run) tick();
    repeat (6) tick();
    chk(sync_o == 1'b0 && sdo_o == 1'b0, "R10", "idle after stop",
        int'({sync_o, sdo_o}), 0);
  endtask

  task automatic drain_rx();
    for (int k = 0; k < 64 && rx_valid; k++) begin
      chk(rq_n > 0 && int'(rx_data) == rq[rq_h], "R6", "rx word",
          int'(rx_data), rq_n > 0 ? rq[rq_h] : -1);
      if (rq_n > 0) begin rq_h = (rq_h + 1) % 64; rq_n--; end
      rx_rd = 1'b1;
      tick();
      rx_rd = 1'b0;
    end
    chk(rq_n == 0, "R6", "rx words left over", rq_n, 0);
  endtask

  task automatic chk_flags(input string req);
    chk(underrun == m_und, req, "underrun flag", int'(underrun), int'(m_und));
    chk(overrun == m_ovr, req, "overrun flag", int'(overrun), int'(m_ovr));
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; enable = 1'b0; sync_mode = 1'b1; tx_irq_en = 1'b0;
    tx_wr = 1'b0; rx_rd = 1'b0; sdi_i = 1'b0; word_len_m1 = 4'd2;
    words_m1 = 4'd2; frame_len = 8'd10; tx_thresh = 4'd0; tx_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({sclk_o, sync_o, sdo_o, tx_irq, underrun, overrun, rx_valid} == 7'd0,
        "R1", "outputs in reset", int'({sclk_o, sync_o, sdo_o, tx_irq, underrun, overrun, rx_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({sync_o, sdo_o, underrun, overrun, rx_valid} == 5'd0, "R1", "outputs after reset",
        int'({sync_o, sdo_o, underrun, overrun, rx_valid}), 0);
    m_prev = sclk_o;

    // R9: interrupt level against threshold
    tx_irq_en = 1'b1; tx_thresh = 4'd3;
    tick();
    chk(tx_irq == 1'b1, "R9", "irq at level 0 thresh 3", int'(tx_irq), 1);
    push_tx(16'h0005); push_tx(16'h0002);
    tick();
    chk(tx_irq == 1'b1, "R9", "irq at level 2 thresh 3", int'(tx_irq), 1);
    push_tx(16'h0007);
    tick();
    chk(tx_irq == 1'b0, "R9", "irq at level 3 thresh 3", int'(tx_irq), 0);
    tx_irq_en = 1'b0;
    tick();
    chk(tx_irq == 1'b0, "R9", "irq disabled", int'(tx_irq), 0);

    // R4, R3: pulse mode, 3 words of 3 bits, frame of 10
    set_cfg(1'b1, 2, 2, 10);
    fill_to(6);
    run_frames(2);
    drain_rx();
    // R5: wide mode, same frame shape
    set_cfg(1'b0, 2, 2, 10);
    fill_to(6);
    run_frames(2);
    drain_rx();
    // R3: frame shorter than its words, second word cut off
    set_cfg(1'b1, 3, 3, 7);
    fill_to(4);
    run_frames(2);
    drain_rx();
    // R3: full 16-bit words
    set_cfg(1'b0, 15, 1, 40);
    fill_to(4);
    run_frames(2);
    drain_rx();
    chk_flags("R7");

    // random frame shapes and modes
    for (int it = 0; it < 25; it++) begin
      int wl, wp;
      wl = int'($urandom % 16);
      wp = int'($urandom % 4);
      set_cfg(1'($urandom % 2), wl, wp, (wp + 1) * (wl + 1) + 1 + int'($urandom % 4));
      fill_to(2 * (wp + 1));
      run_frames(2);
      drain_rx();
    end
    chk_flags("R8");

    // R7: transmit FIFO runs dry, word goes out as zeros
    set_cfg(1'b1, 7, 0, 10);
    run_frames(tq_n + 1);
    chk(underrun == 1'b1, "R7", "underrun set", int'(underrun), 1);
    drain_rx();
    chk_flags("R7");

    // R11: ninth write into a full transmit FIFO is dropped
    for (int k = 0; k < TXD; k++) push_tx(8'h11 * (k + 1));
    push_tx(16'h00FF);
    run_frames(TXD);
    drain_rx();
    run_frames(1);
    drain_rx();
    chk_flags("R11");

    // R8: receive FIFO fills, later words dropped
    set_cfg(1'b0, 1, 3, 12);
    fill_to(8);
    run_frames(3);
    chk(overrun == 1'b1, "R8", "overrun set", int'(overrun), 1);
    drain_rx();
    chk_flags("R8");

    // R10: stays quiet while disabled
    repeat (40) tick();
    chk(rx_valid == 1'b0, "R10", "no rx while stopped", int'(rx_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule